// File: doc/BRIEF.md
# Dual-Mode Serial Bit Buffer

The block takes a stream of already-demodulated bits and stores them in a circular buffer of 128 entries. A host microcontroller reads them out serially, one bit per clock. Each bit arrives as a one-cycle strobe with its data value. A separate flag marks that the stream's sync word has been found. After a clear, no bit is stored until that flag has been seen once. From then on, every strobed bit is stored.

Two inputs pick the operating mode:

- **Master:** the block generates its own serial clock and data. Each stored bit is held across a high and a low clock phase, and the host captures on the falling edge. The shared status output shows, active low, that a sync detection has occurred.
- **Slave:** the host drives the serial clock. The status output becomes an active-low READY flag, and each completed host clock cycle consumes one bit.
- **Standby and test:** both freeze all activity.

Master and slave share one read position. A live switch between the two modes therefore continues the stream without losing or repeating a bit.

Top module: `dual_mode_bit_buffer`

## Requirements
- R1: Mode decode uses {sel_test_i, sel_mode_i}: 00 is master, 01 is slave, 10 is standby, 11 is test. clk_oe_o is 1 only in master.
- R2: After reset or clear, strobed bits are discarded until id_det_i has been sampled high once. Afterwards every strobed bit is stored, whatever id_det_i does.
- R3: The buffer holds up to DEPTH (128) bits. A bit that arrives while the buffer is full is dropped and sets ovf_o. ovf_o stays set until reset or clear.
- R4: In slave mode, stat_no is 0 when at least one unread bit was stored at the previous clock edge, and 1 otherwise. It is updated one cycle after the buffer changes.
- R5: In slave mode, host_clk_i passes through a two-flop synchronizer. Each falling edge then consumes one bit. A falling edge seen while stat_no is 1 consumes nothing.
- R6: In slave mode, dat_o shows the oldest unread bit. It stays constant until the host clock falling edge that consumes it.
- R7: A clear (clr_i=1) resets the sync-seen state and ovf_o in every mode. In slave mode it also empties the buffer, and stat_no reads 1 on the next cycle.
- R8: After reset or clear, clk_o and dat_o are 1 until the first sync detection in master mode.
- R9: In master mode, each stored bit, oldest first, sets dat_o and raises clk_o for HALF_CYC cycles, then lowers clk_o for HALF_CYC cycles with dat_o unchanged. When nothing is stored, clk_o stays 0.
- R10: The read position is shared by both modes. After a switch, the first bit delivered is the one following the last bit consumed in the other mode.
- R11: In standby and test modes, no bit is stored or consumed and clk_o holds its value. stat_no is 1.
- R12: In master mode, stat_no is 0 if a sync detection has occurred since reset or clear, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous active-high clear of sync state, overflow and (slave) buffer |
| sel_test_i | input | 1 | Mode select, upper bit |
| sel_mode_i | input | 1 | Mode select, lower bit |
| bit_vld_i | input | 1 | One-cycle strobe of an incoming bit |
| bit_i | input | 1 | Incoming bit value |
| id_det_i | input | 1 | Sync/ID detected flag from the demodulator |
| host_clk_i | input | 1 | Host serial clock (slave mode) |
| clk_o | output | 1 | Generated serial clock (master mode) |
| clk_oe_o | output | 1 | Drive enable for the serial clock pin |
| dat_o | output | 1 | Serial data |
| stat_no | output | 1 | Active-low status: sync seen (master) or READY (slave) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check the following on every cycle:

- the fill level never exceeds the depth;
- the overflow flag is sticky and cleared by a clear;
- a slave clear empties the buffer;
- the fill level cannot fall while READY is high in slave mode;
- standby freezes the fill level and the generated clock;
- the master data bit is steady across each falling clock edge.

Exact ordering of delivered bits, the write gating before the first sync detection, READY timing after a host clock falling edge, and continuity across live mode switches are shown only by the bench scenarios. There, a behavioural queue model is compared against the outputs on every clock.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
  typedef enum logic [1:0] {
    OP_MASTER  = 2'd0,
    OP_SLAVE   = 2'd1,
    OP_STANDBY = 2'd2,
    OP_TEST    = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    MS_HOLD = 2'd0,
    MS_IDLE = 2'd1,
    MS_HIGH = 2'd2,
    MS_LOW  = 2'd3
  } mseq_e;

  function automatic op_mode_e decode_mode(input logic test, input logic mode);
    case ({test, mode})
      2'b00:   return OP_MASTER;
      2'b01:   return OP_SLAVE;
      2'b10:   return OP_STANDBY;
      default: return OP_TEST;
    endcase
  endfunction
endpackage

// File: rtl/dmb_bit_ring.sv
module dmb_bit_ring #(
  parameter int DEPTH = 128
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic                       push_bit_i,
  input  logic                       pop_i,
  output logic                       head_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (push_ok && !flush_i) begin
      mem_q[wr_q] <= push_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= bump(wr_q);
      if (pop_ok)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/dmb_host_clk_sync.sv
module dmb_host_clk_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_clk_i,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], host_clk_i};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign fall_o = sh_q[2] && !sh_q[1];
endmodule

// File: rtl/dmb_master_seq.sv
module dmb_master_seq
  import dmb_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic park_i,
  input  logic id_seen_i,
  input  logic avail_i,
  input  logic head_i,
  output logic pop_o,
  output logic sclk_o,
  output logic sdat_o
);
  localparam int CNTW = $clog2(HALF_CYC + 1);
  localparam logic [CNTW-1:0] RELOAD = CNTW'(HALF_CYC - 1);

  mseq_e           st_q;
  logic [CNTW-1:0] cnt_q;
  logic            at_end;

  assign at_end = (cnt_q == '0);
  assign pop_o  = run_i && !clr_i && avail_i &&
                  ((st_q == MS_IDLE) || ((st_q == MS_LOW) && at_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MS_HOLD;
      cnt_q  <= '0;
      sclk_o <= 1'b1;
      sdat_o <= 1'b1;
    end else if (clr_i) begin
      st_q   <= MS_HOLD;
      cnt_q  <= '0;
      sclk_o <= 1'b1;
      sdat_o <= 1'b1;
    end else if (run_i) begin
      if (pop_o) begin
        st_q   <= MS_HIGH;
        cnt_q  <= RELOAD;
        sclk_o <= 1'b1;
        sdat_o <= head_i;
      end else begin
        case (st_q)
          MS_HOLD: if (id_seen_i) begin
            st_q   <= MS_IDLE;
            sclk_o <= 1'b0;
          end
          MS_HIGH: if (at_end) begin
            st_q   <= MS_LOW;
            cnt_q  <= RELOAD;
            sclk_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
          MS_LOW: if (at_end) st_q <= MS_IDLE;
                  else        cnt_q <= cnt_q - 1'b1;
          default: ;
        endcase
      end
    end else if (park_i && st_q != MS_HOLD) begin
      st_q   <= MS_IDLE;
      sclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_mode_bit_buffer.sv
module dual_mode_bit_buffer
  import dmb_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel_test_i,
  input  logic sel_mode_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic id_det_i,
  input  logic host_clk_i,
  output logic clk_o,
  output logic clk_oe_o,
  output logic dat_o,
  output logic stat_no,
  output logic ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  op_mode_e      op;
  logic          is_m, is_s, active;
  logic          id_seen_q, ready_n_q, ovf_q;
  logic          fall, m_pop, s_pop, push, head, full;
  logic          m_clk, m_dat;
  logic [CW-1:0] fill_cnt;

  assign op     = decode_mode(sel_test_i, sel_mode_i);
  assign is_m   = (op == OP_MASTER);
  assign is_s   = (op == OP_SLAVE);
  assign active = is_m || is_s;

  assign push  = active && !clr_i && bit_vld_i && id_seen_q;
  assign s_pop = is_s && !clr_i && fall && !ready_n_q && (fill_cnt != '0);

  dmb_host_clk_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_clk_i (host_clk_i),
    .fall_o     (fall)
  );

  dmb_bit_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (clr_i && is_s),
    .push_i     (push),
    .push_bit_i (bit_i),
    .pop_i      (m_pop || s_pop),
    .head_o     (head),
    .full_o     (full),
    .count_o    (fill_cnt)
  );

  dmb_master_seq #(.HALF_CYC(HALF_CYC)) u_mseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .run_i     (is_m),
    .park_i    (is_s),
    .id_seen_i (id_seen_q),
    .avail_i   (fill_cnt != '0),
    .head_i    (head),
    .pop_o     (m_pop),
    .sclk_o    (m_clk),
    .sdat_o    (m_dat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_seen_q <= 1'b0;
      ready_n_q <= 1'b1;
      ovf_q     <= 1'b0;
    end else if (clr_i) begin
      id_seen_q <= 1'b0;
      ready_n_q <= 1'b1;
      ovf_q     <= 1'b0;
    end else if (active) begin
      if (id_det_i) id_seen_q <= 1'b1;
      if (push && full) ovf_q <= 1'b1;
      ready_n_q <= (fill_cnt == '0);
    end
  end

  assign clk_o    = m_clk;
  assign clk_oe_o = is_m;
  assign dat_o    = is_s ? head : m_dat;
  assign stat_no  = is_m ? !id_seen_q : (is_s ? ready_n_q : 1'b1);
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/dmb_checker.sv
module dmb_checker #(
  parameter int DEPTH = 128
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clr_i,
  input logic                       sel_test_i,
  input logic                       sel_mode_i,
  input logic                       clk_o,
  input logic                       dat_o,
  input logic                       stat_no,
  input logic                       ovf_o,
  input logic [$clog2(DEPTH+1)-1:0] fill_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic mst, slv, stby;
  assign mst  = !sel_test_i && !sel_mode_i;
  assign slv  = !sel_test_i && sel_mode_i;
  assign stby = sel_test_i;

  a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH));

  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);

  a_r7_ovf_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ovf_o);

  a_r7_slave_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && slv) |=> (fill_i == '0));

  a_r8_clk_high_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> clk_o);

  a_r5_no_pop_when_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv && stat_no && !clr_i) |=> (fill_i >= $past(fill_i)));

  a_r11_standby_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby && !clr_i) |=> ($stable(fill_i) && $stable(clk_o)));

  a_r9_data_steady_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst && $past(mst) && $fell(clk_o)) |-> $stable(dat_o));
endmodule

bind dual_mode_bit_buffer dmb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .sel_test_i (sel_test_i),
  .sel_mode_i (sel_mode_i),
  .clk_o      (clk_o),
  .dat_o      (dat_o),
  .stat_no    (stat_no),
  .ovf_o      (ovf_o),
  .fill_i     (fill_cnt)
);

// File: tb/dual_mode_bit_buffer_bench.sv
`timescale 1ns/1ps
module dual_mode_bit_buffer_bench;
  localparam int DEPTH = 128;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, tst = 0, mde = 0, bv = 0, bd = 0, idd = 0, hclk = 0;
  logic clk_o, clk_oe, dat_o, stat_no, ovf_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  dual_mode_bit_buffer #(.DEPTH(DEPTH), .HALF_CYC(HALF)) u_dual_mode_bit_buffer (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sel_test_i(tst), .sel_mode_i(mde),
    .bit_vld_i(bv), .bit_i(bd), .id_det_i(idd), .host_clk_i(hclk),
    .clk_o(clk_o), .clk_oe_o(clk_oe), .dat_o(dat_o), .stat_no(stat_no), .ovf_o(ovf_o)
  );

  // behavioural reference model
  bit q[$];
  bit m_id, m_ovf, m_rdy_n, m_clk, m_dat, s1, s2, s3;
  int m_st, m_cnt; // 0 hold, 1 idle, 2 high, 3 low

  task automatic model_reset();
    q.delete(); m_id = 0; m_ovf = 0; m_rdy_n = 1; m_clk = 1; m_dat = 1;
    m_st = 0; m_cnt = 0; s1 = 0; s2 = 0; s3 = 0;
  endtask

  task automatic model_step();
    bit f, m, s, id_pre, h, pop;
    int n;
    f = s3 & ~s2; s3 = s2; s2 = s1; s1 = hclk;
    m = !tst && !mde; s = !tst && mde;
    n = q.size(); h = (n > 0) ? q[0] : 1'b0; id_pre = m_id;
    if (clr) begin
      m_id = 0; m_ovf = 0; m_rdy_n = 1; m_st = 0; m_clk = 1; m_dat = 1; m_cnt = 0;
      if (s) q.delete();
    end else if (m || s) begin
      pop = (m && n > 0 && (m_st == 1 || (m_st == 3 && m_cnt == 0))) ||
            (s && f && !m_rdy_n && n > 0);
      if (bv && id_pre && n == DEPTH) m_ovf = 1;
      if (pop) void'(q.pop_front());
      if (bv && id_pre && n < DEPTH) q.push_back(bd);
      m_rdy_n = (n == 0);
      if (idd) m_id = 1;
      if (m) begin
        if (n > 0 && (m_st == 1 || (m_st == 3 && m_cnt == 0))) begin
          m_st = 2; m_clk = 1; m_dat = h; m_cnt = HALF - 1;
        end else if (m_st == 0) begin
          if (id_pre) begin m_st = 1; m_clk = 0; end
        end else if (m_st == 2) begin
          if (m_cnt == 0) begin m_st = 3; m_clk = 0; m_cnt = HALF - 1; end
          else m_cnt--;
        end else if (m_st == 3) begin
          if (m_cnt == 0) m_st = 1; else m_cnt--;
        end
      end else if (m_st != 0) begin
        m_st = 1; m_clk = 0;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m, s;
      m = !tst && !mde; s = !tst && mde;
      chk({cur, " R1 clk_oe"}, clk_oe, m);
      chk({cur, " R9 clk"}, clk_o, m_clk);
      chk({cur, " R3 ovf"}, ovf_o, m_ovf);
      if (m) begin
        chk({cur, " R9 dat"}, dat_o, m_dat);
        chk({cur, " R12 stat"}, stat_no, !m_id);
      end else if (s) begin
        if (q.size() > 0) chk({cur, " R6 dat"}, dat_o, q[0]);
        chk({cur, " R4 ready"}, stat_no, m_rdy_n);
      end else begin
        chk({cur, " R11 stat"}, stat_no, 1);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send_bit(bit b, int gap);
    bv = 1; bd = b; tick(1); bv = 0; tick(gap);
  endtask

  task automatic host_cycle();
    hclk = 1; tick(4); hclk = 0; tick(6);
  endtask

  task automatic drain_slave();
    for (int g = 0; g < 300 && stat_no == 0; g++) host_cycle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    cur = "R8";
    chk("R8 reset clk_o", clk_o, 1);
    chk("R8 reset dat_o", dat_o, 1);
    chk("R12 reset stat_no", stat_no, 1);
    chk("R3 reset ovf_o", ovf_o, 0);

    cur = "R2";
    for (int k = 0; k < 5; k++) send_bit(k[0], 3);
    chk("R8 clk_o before id", clk_o, 1);
    mde = 1; tick(3);
    chk("R2 nothing stored before id", stat_no, 1);
    mde = 0; tick(2);

    cur = "R12";
    idd = 1; tick(1); idd = 0; tick(1);
    chk("R12 stat after id", stat_no, 0);
    cur = "R9";
    for (int k = 0; k < 12; k++) send_bit(((k * 7) % 3) == 0, 11);
    tick(20);

    cur = "R10";
    for (int k = 0; k < 6; k++) send_bit(k[1] ^ k[0], 0);
    tick(11);
    mde = 1; tick(6);
    drain_slave();
    chk("R10 slave drained", stat_no, 1);

    cur = "R5";
    host_cycle(); host_cycle();
    send_bit(1, 6);
    chk("R5 ready after push", stat_no, 0);
    chk("R5 bit kept", dat_o, 1);
    host_cycle();
    chk("R5 one pop per host clock", stat_no, 1);

    cur = "R3";
    for (int k = 0; k < DEPTH + 3; k++) begin
      bv = 1; bd = k[0] ^ k[2]; tick(1);
    end
    bv = 0; tick(2);
    chk("R3 overflow set", ovf_o, 1);
    for (int k = 0; k < 3; k++) host_cycle();

    cur = "R11";
    tst = 1; tick(1);
    for (int k = 0; k < 3; k++) send_bit(1, 1);
    host_cycle();
    mde = 0; tick(1);
    send_bit(0, 2);
    host_cycle();
    tst = 0; mde = 1; tick(2);
    chk("R11 ovf held", ovf_o, 1);
    chk("R11 data still ready", stat_no, 0);

    cur = "R7";
    clr = 1; tick(1); clr = 0; tick(1);
    chk("R7 ready high after clear", stat_no, 1);
    chk("R7 ovf cleared", ovf_o, 0);
    cur = "R2";
    for (int k = 0; k < 3; k++) send_bit(1, 2);
    chk("R2 gated after clear", stat_no, 1);
    idd = 1; tick(1); idd = 0;
    for (int k = 0; k < 5; k++) send_bit(k[0], 1);
    tick(2);
    host_cycle(); host_cycle();

    cur = "R10";
    mde = 0; tick(60);
    chk("R10 master idle low", clk_o, 0);

    cur = "R8";
    for (int k = 0; k < 4; k++) send_bit(!k[0], 0);
    tick(3);
    clr = 1; tick(1); clr = 0; tick(1);
    chk("R8 clk_o high after clear", clk_o, 1);
    chk("R8 dat_o high after clear", dat_o, 1);
    tick(10);
    chk("R8 still held", clk_o, 1);
    idd = 1; tick(1); idd = 0;
    tick(60);

    done = 1;
    summary();
    $finish;
  end
endmodule